// File: doc/BRIEF.md
# Coprocessor Memory Read Engine

This block sits on the host side of a host/coprocessor pair. It fetches 16-bit words from the coprocessor's memory and queues them in a 16-entry read FIFO, which the host drains one word per pop. The host sets up a transfer through a 16-bit control word. That word selects the memory space, the burst length (one word, eight words, sixteen words or an open-ended stream), address auto-increment, the coprocessor reset line and four interrupt enables. A separate 16-bit register holds the low half of the coprocessor address. The coprocessor supplies the high half on an input.

On the coprocessor side the block raises a request, with the address and the memory-space code, and waits for an acknowledge that carries the word. A word is taken on any clock edge where request and acknowledge are both high. Requests stop while the FIFO has no free entry or the coprocessor is held in reset. A status word reports the transfer state, the reset state, the read-FIFO levels and two write-direction levels that arrive as inputs. A single level interrupt combines the enabled status conditions.

Top module: `cop_rd_engine`

## Requirements
- R1: After reset, `cfg_q`, `adr_q` and `pop_data` are zero, `cop_req`, `cop_rst` and `irq` are low, and every `stat` bit is zero except bits 7 and 8, which follow their inputs.
- R2: A control write with bit 4 set, made while no transfer runs, starts a transfer. `stat` bit 0 is 1 from the next cycle until the transfer ends. `cop_req` stays low while no transfer runs.
- R3: Control bits 3:2 are sampled at the start of a transfer and give its length: 0 is 1 word, 1 is 8 words, 2 is 16 words. After that many accepted words, `stat` bit 0 returns to 0.
- R4: `cop_addr` is {`cop_hi_addr`, `adr_q`}. When control bit 1 is 1, `adr_q` increases by one per accepted word. When it is 0, `adr_q` does not change. The low address stays stable while a request waits for its acknowledge.
- R5: `cop_space` carries control bits 15:12 (0 data memory, 1 register space, 5 program memory).
- R6: The read FIFO holds 16 words in arrival order. A pop of a non-empty FIFO puts the oldest word on `pop_data` one cycle later. `stat` bit 5 is FIFO full and `stat` bit 6 is FIFO not-empty.
- R7: Length code 3 streams without end. Requests stop while the FIFO is full and resume after a pop. A control write with bit 4 clear ends the stream.
- R8: A control write with bit 4 set during a running transfer does not restart it or change its remaining length.
- R9: A pop of an empty FIFO leaves `pop_data` and the FIFO unchanged.
- R10: Control bit 0 drives `cop_rst`. A rise of the bit holds `cop_rst` high for at least 8 cycles, even if the bit is cleared sooner. `stat` bit 2 equals `cop_rst`, and no request is issued while it is high.
- R11: `stat` bit 7 reports `wf_full` and `stat` bit 8 reports `wf_empty`.
- R12: `irq` is high exactly when some status bit k in {5,6,7,8} is 1 together with control bit k.
- R13: A word is accepted on a clock edge where `cop_req` and `cop_ack` are both high, and `cop_rdata` is written into the FIFO at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_q | output | 16 | Control word readback |
| adr_we | input | 1 | Low address write strobe |
| adr_wdata | input | 16 | Low address write data |
| adr_q | output | 16 | Current low address |
| pop | input | 1 | Read FIFO pop request |
| pop_data | output | 16 | Word delivered by the last effective pop |
| stat | output | 16 | Status word |
| irq | output | 1 | Level interrupt |
| wf_full | input | 1 | Write-direction FIFO full |
| wf_empty | input | 1 | Write-direction FIFO empty |
| cop_hi_addr | input | 16 | High address half from the coprocessor |
| cop_req | output | 1 | Word read request |
| cop_addr | output | 32 | Word read address |
| cop_space | output | 4 | Memory space code |
| cop_ack | input | 1 | Read acknowledge |
| cop_rdata | input | 16 | Read data, valid with acknowledge |
| cop_rst | output | 1 | Coprocessor reset |

## Verification
A wrong pointer or a wrong level count shows up at the first pop as a misordered or repeated word, or one pop too soon as a wrong full or not-empty flag. A wrong length or address-increment decision shows up when `stat` bit 0 clears, through the number of words left in the FIFO and through the final `adr_q`. A free-run that fails to stall either overflows, and then drops or repeats addresses in the popped stream, or keeps `cop_req` high while the FIFO is full, which is visible in the same cycle. A wrong reset-hold count changes how many cycles `cop_rst` stays high after a short pulse.

// File: rtl/cop_rd_engine.sv
module cop_rd_engine #(
  parameter int DW       = 16,
  parameter int DEPTH    = 16,
  parameter int RST_HOLD = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_q,
  input  logic          adr_we,
  input  logic [15:0]   adr_wdata,
  output logic [15:0]   adr_q,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [15:0]   stat,
  output logic          irq,
  input  logic          wf_full,
  input  logic          wf_empty,
  input  logic [15:0]   cop_hi_addr,
  output logic          cop_req,
  output logic [31:0]   cop_addr,
  output logic [3:0]    cop_space,
  input  logic          cop_ack,
  input  logic [DW-1:0] cop_rdata,
  output logic          cop_rst
);
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int HW  = $clog2(RST_HOLD + 1);
  localparam int LCW = 5;

  logic [15:0]   cfg_r, adr_r;
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [DW-1:0] pop_q;
  logic          run_r, free_r;
  logic [LCW-1:0] left_r;
  logic [HW-1:0] hold_r;

  logic full, empty, take, pop_ok, start, stop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign cop_rst = cfg_r[0] || (hold_r != '0);
  assign cop_req = run_r && !cop_rst && !full;
  assign take    = cop_req && cop_ack;
  assign pop_ok  = pop && !empty;
  assign start   = cfg_we && cfg_wdata[4] && !run_r;
  assign stop    = cfg_we && !cfg_wdata[4] && run_r && free_r;

  assign cop_addr  = {cop_hi_addr, adr_r};
  assign cop_space = cfg_r[15:12];
  assign cfg_q     = cfg_r;
  assign adr_q     = adr_r;
  assign pop_data  = pop_q;

  assign stat = {7'd0, wf_empty, wf_full, !empty, full, 2'b00, cop_rst, 1'b0, run_r};
  assign irq  = |(cfg_r[8:5] & stat[8:5]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_r  <= '0;
      hold_r <= '0;
    end else begin
      if (cfg_we) cfg_r <= cfg_wdata;
      if (cfg_we && cfg_wdata[0] && !cfg_r[0]) hold_r <= HW'(RST_HOLD);
      else if (hold_r != '0)                  hold_r <= hold_r - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    adr_r <= '0;
    else if (adr_we)               adr_r <= adr_wdata;
    else if (take && cfg_r[1])     adr_r <= adr_r + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_r  <= 1'b0;
      free_r <= 1'b0;
      left_r <= '0;
    end else if (start) begin
      run_r  <= 1'b1;
      free_r <= (cfg_wdata[3:2] == 2'd3);
      case (cfg_wdata[3:2])
        2'd0:    left_r <= LCW'(1);
        2'd1:    left_r <= LCW'(8);
        default: left_r <= LCW'(16);
      endcase
    end else if (run_r) begin
      if (take) left_r <= left_r - 1'b1;
      if (stop) run_r <= 1'b0;
      else if (take && !free_r && left_r == LCW'(1)) run_r <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) mem[wp] <= cop_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      pop_q <= '0;
    end else begin
      if (take) wp <= wp + 1'b1;
      if (pop_ok) begin
        rp    <= rp + 1'b1;
        pop_q <= mem[rp];
      end
      case ({take, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  logic [HW-1:0] rst_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !cop_rst)              rst_len <= '0;
    else if (rst_len != HW'(RST_HOLD))   rst_len <= rst_len + 1'b1;
  end

  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(cop_rst) |-> rst_len == HW'(RST_HOLD)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cop_req && !cop_ack && !adr_we) |=> (!cop_req || $stable(cop_addr[15:0]))); // R4
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (pop && stat[6] == 1'b0 && !take) |=> ($stable(pop_data) && stat[6] == 1'b0)); // R9
  AST_STREAM_STOP: assert property (@(posedge clk) disable iff (!rst_n) (stat[0] && free_r && cfg_we && !cfg_wdata[4]) |=> !stat[0]); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!stat[0] && !start) |=> !cop_req); // R2
endmodule

// File: tb/sim_cop_rd_engine.sv
module sim_cop_rd_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, adr_we = 0, pop = 0, wf_full = 0, wf_empty = 0, cop_ack = 0;
  logic [15:0] cfg_wdata = 0, adr_wdata = 0, cop_hi_addr = 16'h0042, cop_rdata = 0;
  logic [15:0] cfg_q, adr_q, pop_data, stat;
  logic [31:0] cop_addr;
  logic [3:0]  cop_space;
  logic irq, cop_req, cop_rst;
  logic mem_en = 1'b1;
  int checks = 0, errors = 0, cyc = 0, rst_cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_rd_engine u0 (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .adr_we(adr_we), .adr_wdata(adr_wdata), .adr_q(adr_q), .pop(pop), .pop_data(pop_data),
    .stat(stat), .irq(irq), .wf_full(wf_full), .wf_empty(wf_empty), .cop_hi_addr(cop_hi_addr),
    .cop_req(cop_req), .cop_addr(cop_addr), .cop_space(cop_space), .cop_ack(cop_ack),
    .cop_rdata(cop_rdata), .cop_rst(cop_rst));

  function automatic logic [15:0] memword(input logic [3:0] sp, input logic [31:0] a);
    logic [31:0] t;
    t = a[15:0] * 32'd40503 + {16'd0, a[31:16]} * 32'd977 + {28'd0, sp} * 32'd4099;
    return t[15:0] ^ t[31:16];
  endfunction

  function automatic logic [15:0] len_of(input logic [1:0] code);
    return (code == 2'd0) ? 16'd1 : (code == 2'd1) ? 16'd8 : 16'd16;
  endfunction

  always @(negedge clk) begin
    cop_ack   <= mem_en && cop_req && ($urandom % 3 != 0);
    cop_rdata <= memword(cop_space, cop_addr);
    if (cop_rst) rst_cycles <= rst_cycles + 1;
  end

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [15:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic adr_wr(input logic [15:0] v);
    @(negedge clk); adr_we = 1; adr_wdata = v;
    @(negedge clk); adr_we = 0;
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && stat[0]; i++) @(negedge clk);
  endtask

  task automatic drain(input int n, input logic [3:0] sp, input logic [15:0] a0, input bit inc, input string req);
    for (int i = 0; i < n; i++) begin
      logic [15:0] e;
      e = memword(sp, {cop_hi_addr, inc ? a0 + 16'(i) : a0});
      do_pop();
      chk(pop_data == e, req, pop_data, e);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(stat == 16'h0 && cfg_q == 0 && adr_q == 0 && pop_data == 0 && !irq && !cop_req && !cop_rst, "R1", {16'd0, stat}, 0);
    wf_empty = 1; @(negedge clk);
    chk(stat == 16'h0100, "R11 wf_empty", {16'd0, stat}, 32'h100);

    // R3 length 1 with autoinc, R12 not-empty irq, R13
    adr_wr(16'h0100);
    cfg_wr(16'h0052);
    @(negedge clk);
    wait_idle();
    chk(stat[6] && irq && adr_q == 16'h0101, "R3 R12 len1", {16'd0, adr_q}, 32'h101);
    drain(1, 4'd0, 16'h0100, 1, "R13 len1 data");
    chk(!stat[6] && !irq, "R12 irq clears", {31'd0, irq}, 0);
    // R9 pop of empty
    do_pop();
    chk(pop_data == memword(4'd0, {cop_hi_addr, 16'h0100}) && !stat[6], "R9", {16'd0, pop_data}, {16'd0, memword(4'd0, {cop_hi_addr, 16'h0100})});

    // R4 no autoinc, length 8, space 1 (R5)
    adr_wr(16'h0200);
    cfg_wr(16'h1014);
    @(negedge clk);
    chk(cop_space == 4'd1, "R5 space", {28'd0, cop_space}, 1);
    wait_idle();
    chk(adr_q == 16'h0200, "R4 no increment", {16'd0, adr_q}, 32'h200);
    drain(8, 4'd1, 16'h0200, 0, "R4 fixed addr data");

    // R6 length 16 fills, full irq, space 5
    adr_wr(16'h0300);
    cfg_wr(16'h503A);
    @(negedge clk);
    wait_idle();
    chk(stat[5] && irq && adr_q == 16'h0310, "R6 full", {16'd0, stat}, 32'h160);
    drain(16, 4'd5, 16'h0300, 1, "R6 order");
    chk(!stat[6] && !stat[5], "R6 empty", {16'd0, stat}, 0);

    // R7 free-run
    adr_wr(16'h0400);
    cfg_wr(16'h001E);
    for (int i = 0; i < 500 && !stat[5]; i++) @(negedge clk);
    repeat (4) begin
      @(negedge clk);
      chk(!cop_req && stat[0] && stat[5], "R7 stall", {31'd0, cop_req}, 0);
    end
    drain(1, 4'd0, 16'h0400, 1, "R7 first word");
    for (int i = 0; i < 500 && !stat[5]; i++) @(negedge clk);
    chk(stat[5], "R7 resume", {16'd0, stat}, 32'h20);
    cfg_wr(16'h000E);
    @(negedge clk);
    chk(!stat[0], "R7 stop", {16'd0, stat}, 0);
    drain(16, 4'd0, 16'h0401, 1, "R7 stream data");
    chk(adr_q == 16'h0411, "R7 final addr", {16'd0, adr_q}, 32'h411);

    // R8 restart ignored
    mem_en = 0;
    adr_wr(16'h0500);
    cfg_wr(16'h001A);
    cfg_wr(16'h0012);
    mem_en = 1;
    @(negedge clk);
    wait_idle();
    chk(stat[5] && adr_q == 16'h0510, "R8 length kept", {16'd0, adr_q}, 32'h510);
    drain(16, 4'd0, 16'h0500, 1, "R8 data");

    // R10 reset pulse, requests blocked
    rst_cycles = 0;
    adr_wr(16'h0600);
    cfg_wr(16'h0013);
    chk(cop_rst && stat[2] && stat[0] && !cop_req, "R10 blocked", {16'd0, stat}, 32'h5);
    cfg_wr(16'h0002);
    for (int i = 0; i < 100 && cop_rst; i++) @(negedge clk);
    @(negedge clk);
    chk(rst_cycles == 8, "R10 hold length", rst_cycles, 8);
    wait_idle();
    drain(1, 4'd0, 16'h0600, 1, "R10 after release");

    // R11 R12 write-direction flags
    wf_full = 1; wf_empty = 0;
    cfg_wr(16'h0080);
    chk(irq && stat[7] && !stat[8], "R11 R12 wf_full", {31'd0, irq}, 1);
    cfg_wr(16'h0100);
    chk(!irq, "R12 masked", {31'd0, irq}, 0);
    wf_full = 0; wf_empty = 1; @(negedge clk);
    chk(irq, "R12 wf_empty", {31'd0, irq}, 1);
    cfg_wr(16'h0000);

    // random transfers
    for (int k = 0; k < 24; k++) begin
      logic [1:0] lc; bit inc; logic [3:0] sp; logic [15:0] a0; int n; int pick;
      lc = 2'($urandom % 3);
      inc = 1'($urandom % 2);
      pick = $urandom % 3;
      sp = (pick == 0) ? 4'd0 : (pick == 1) ? 4'd1 : 4'd5;
      a0 = 16'($urandom);
      cop_hi_addr = 16'($urandom);
      n = int'(len_of(lc));
      adr_wr(a0);
      cfg_wr({sp, 7'd0, 1'b1, lc, inc, 1'b0});
      @(negedge clk);
      wait_idle();
      chk(adr_q == (inc ? a0 + 16'(n) : a0), "R3 R4 random addr", {16'd0, adr_q}, {16'd0, inc ? a0 + 16'(n) : a0});
      drain(n, sp, a0, inc, "R3 R5 R6 random data");
      chk(!stat[6], "R3 random count", {16'd0, stat}, 0);
    end
    finish_up();
  end
endmodule